// File: doc/BRIEF.md
# Compare-and-Branch Next-PC Unit

This block decides where a simple 64-bit processor fetches next. Each cycle it receives the current program counter, the byte length of the instruction being executed, a set of decoded class strobes (stop, return, call, jump, compare-and-branch), a 4-bit condition selector, two 64-bit operands to compare, a 32-bit absolute target and the register value a return reads. It produces the next program counter, a halt indication, a redirect indication, an illegal-condition flag, and, for a call, the link value with its write strobe for the register file.

Branch conditions are evaluated directly on the two operands, so no flags register exists. Call and return link through a general register instead of a stack. A return to address zero, or to an address with its top bit set, halts the machine. The decision path is purely combinational. When the `PC_REG` parameter is 1, a PC register captures the next PC on each clock where `step_en` is high.

Top module: `npc_unit`

## Requirements
- R1: With no class strobe set, or with a branch not taken, `next_pc` equals `pc_cur + ins_len` modulo 2^64, and `redirect` is 0.
- R2: Condition 4'h0 takes the branch when `opnd_a == opnd_b`, and condition 4'h1 takes it when they differ. A taken branch sets `next_pc` to the 32-bit target zero-extended, with `redirect` = 1.
- R3: Conditions 4'h4, 4'h5, 4'h6 and 4'h7 compare `opnd_a` against `opnd_b` as two's-complement numbers, taking the branch on a<b, a<=b, a>b and a>=b respectively.
- R4: Conditions 4'h8, 4'h9, 4'hA and 4'hB compare `opnd_a` against `opnd_b` as unsigned magnitudes, taking the branch on a>b, a>=b, a<b and a<=b respectively.
- R5: A branch with condition 4'h2, 4'h3 or 4'hC through 4'hF falls through as not taken and raises `illegal_cc`. `illegal_cc` is 0 whenever the selected operation is not a branch.
- R6: A jump sets `next_pc` to the zero-extended target with `redirect` = 1, whatever the condition and the operands are.
- R7: A call sets `next_pc` to the zero-extended target, raises `link_we`, and drives `link_data` = `pc_cur + ins_len`. `link_we` is 0 for every other operation.
- R8: A return whose `ret_addr` is nonzero and has bit 63 clear sets `next_pc` = `ret_addr` with `redirect` = 1. A return to zero, or to an address with bit 63 set, raises `halt` instead.
- R9: A stop raises `halt`. Whenever `halt` is 1, `next_pc` equals `pc_cur` and `redirect` is 0.
- R10: When several strobes are set, the first one in the order stop, return, call, jump, branch takes effect and the others are ignored.
- R11: With `PC_REG` = 1, `pc_q` resets to `RESET_PC`. On a rising clock edge with `step_en` high it loads `next_pc`, and with `step_en` low it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Clock enable for the PC register |
| pc_cur | input | 64 | Address of the current instruction |
| ins_len | input | 4 | Byte length of the current instruction |
| op_stop | input | 1 | Decoded stop |
| op_ret | input | 1 | Decoded return through a register |
| op_call | input | 1 | Decoded call |
| op_jmp | input | 1 | Decoded unconditional jump |
| op_cbr | input | 1 | Decoded compare-and-branch |
| cond | input | 4 | Branch condition selector |
| opnd_a | input | 64 | First comparison operand |
| opnd_b | input | 64 | Second comparison operand |
| br_target | input | 32 | Absolute target address |
| ret_addr | input | 64 | Register value used by a return |
| next_pc | output | 64 | Address of the next instruction |
| halt | output | 1 | Machine stops |
| redirect | output | 1 | Next PC departs from sequential flow |
| illegal_cc | output | 1 | Branch used a reserved condition |
| link_we | output | 1 | Write strobe for the return address |
| link_data | output | 64 | Return address to write |
| pc_q | output | 64 | Registered program counter |

## Verification
The bench targets operand pairs where the signed and unsigned orders disagree, such as all-ones against one, or the most negative value against zero. A comparator that used a single ordering for both groups of conditions would branch the wrong way on these pairs. It compares equal operands under every ordering condition, which catches an off-by-one between strict and non-strict comparisons, and it runs every reserved condition to confirm the branch falls through with the flag raised. It also checks returns to zero and to negative addresses, stacks several class strobes at once to test priority, and uses a PC near 2^64 to confirm the sequential address wraps instead of carrying out.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [3:0] CC_EQ = 4'h0;
  localparam logic [3:0] CC_NE = 4'h1;
  localparam logic [3:0] CC_LT = 4'h4;
  localparam logic [3:0] CC_LE = 4'h5;
  localparam logic [3:0] CC_GT = 4'h6;
  localparam logic [3:0] CC_GE = 4'h7;
  localparam logic [3:0] CC_AB = 4'h8;
  localparam logic [3:0] CC_AE = 4'h9;
  localparam logic [3:0] CC_BL = 4'hA;
  localparam logic [3:0] CC_BE = 4'hB;

  typedef enum logic [2:0] {
    KIND_SEQ  = 3'd0,
    KIND_BR   = 3'd1,
    KIND_JMP  = 3'd2,
    KIND_CALL = 3'd3,
    KIND_RET  = 3'd4,
    KIND_STOP = 3'd5
  } npc_kind_e;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [3:0]      cc,
  output logic            take,
  output logic            rsvd
);

  logic eq, ult, slt;

  assign eq  = (a == b);
  assign ult = (a < b);
  assign slt = ($signed(a) < $signed(b));

  always_comb begin
    take = 1'b0;
    rsvd = 1'b0;
    case (cc)
      CC_EQ:   take = eq;
      CC_NE:   take = !eq;
      CC_LT:   take = slt;
      CC_LE:   take = slt || eq;
      CC_GT:   take = !(slt || eq);
      CC_GE:   take = !slt;
      CC_AB:   take = !(ult || eq);
      CC_AE:   take = !ult;
      CC_BL:   take = ult;
      CC_BE:   take = ult || eq;
      default: rsvd = 1'b1;
    endcase
  end

  // R5: a reserved selector never yields a taken decision
  always_comb begin
    if (rsvd) a_r5_rsvd_not_taken: assert (!take);
  end

endmodule

// File: rtl/npc_class_pick.sv
module npc_class_pick
  import npc_pkg::*;
(
  input  logic      op_stop,
  input  logic      op_ret,
  input  logic      op_call,
  input  logic      op_jmp,
  input  logic      op_cbr,
  output npc_kind_e kind
);

  always_comb begin
    if (op_stop)      kind = KIND_STOP;
    else if (op_ret)  kind = KIND_RET;
    else if (op_call) kind = KIND_CALL;
    else if (op_jmp)  kind = KIND_JMP;
    else if (op_cbr)  kind = KIND_BR;
    else              kind = KIND_SEQ;
  end

  // R10: the stop strobe always wins
  always_comb begin
    if (op_stop) a_r10_stop_first: assert (kind == KIND_STOP);
  end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int               XLEN     = 64,
  parameter logic [XLEN-1:0]  RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);

  logic [XLEN-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_PC;
    else        q <= q_nxt;
  end

  // R11: load on enable, hold otherwise
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int                XLEN     = 64,
  parameter int                TGT_W    = 32,
  parameter int                LEN_W    = 4,
  parameter bit                PC_REG   = 1'b1,
  parameter logic [XLEN-1:0]   RESET_PC = 64'h0000_0000_0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [LEN_W-1:0]  ins_len,
  input  logic              op_stop,
  input  logic              op_ret,
  input  logic              op_call,
  input  logic              op_jmp,
  input  logic              op_cbr,
  input  logic [3:0]        cond,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [TGT_W-1:0]  br_target,
  input  logic [XLEN-1:0]   ret_addr,
  output logic [XLEN-1:0]   next_pc,
  output logic              halt,
  output logic              redirect,
  output logic              illegal_cc,
  output logic              link_we,
  output logic [XLEN-1:0]   link_data,
  output logic [XLEN-1:0]   pc_q
);

  localparam int SIGN_BIT = XLEN - 1;

  npc_kind_e       kind;
  logic            br_take, br_rsvd;
  logic [XLEN-1:0] seq_pc, tgt_pc;
  logic            ret_bad;

  npc_class_pick u_pick (
    .op_stop (op_stop),
    .op_ret  (op_ret),
    .op_call (op_call),
    .op_jmp  (op_jmp),
    .op_cbr  (op_cbr),
    .kind    (kind)
  );

  npc_cond_eval #(.XLEN(XLEN)) u_cmp (
    .a    (opnd_a),
    .b    (opnd_b),
    .cc   (cond),
    .take (br_take),
    .rsvd (br_rsvd)
  );

  assign seq_pc  = pc_cur + XLEN'(ins_len);
  assign tgt_pc  = XLEN'(br_target);
  assign ret_bad = (ret_addr == '0) || ret_addr[SIGN_BIT];

  always_comb begin
    next_pc    = seq_pc;
    halt       = 1'b0;
    redirect   = 1'b0;
    illegal_cc = 1'b0;
    link_we    = 1'b0;
    case (kind)
      KIND_STOP: begin
        halt    = 1'b1;
        next_pc = pc_cur;
      end
      KIND_RET: begin
        if (ret_bad) begin
          halt    = 1'b1;
          next_pc = pc_cur;
        end else begin
          redirect = 1'b1;
          next_pc  = ret_addr;
        end
      end
      KIND_CALL: begin
        link_we  = 1'b1;
        redirect = 1'b1;
        next_pc  = tgt_pc;
      end
      KIND_JMP: begin
        redirect = 1'b1;
        next_pc  = tgt_pc;
      end
      KIND_BR: begin
        illegal_cc = br_rsvd;
        if (br_take) begin
          redirect = 1'b1;
          next_pc  = tgt_pc;
        end
      end
      default: next_pc = seq_pc;
    endcase
  end

  assign link_data = seq_pc;

  generate
    if (PC_REG) begin : g_pc_reg
      npc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (step_en),
        .d     (next_pc),
        .q     (pc_q)
      );
    end else begin : g_pc_comb
      assign pc_q = next_pc;
    end
  endgenerate

  // R9: a halting cycle keeps the current address and never redirects
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (next_pc == pc_cur) && !redirect);

  // R7: the link strobe goes with a jump to the target and no halt
  a_r7_call_links: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (next_pc == XLEN'(br_target)) && !halt && op_call);

  // R8: a good return follows the register value
  a_r8_ret_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ret && !op_stop && (ret_addr != '0) && !ret_addr[SIGN_BIT])
      |-> (next_pc == ret_addr) && !halt);

  // R5: the illegal flag only appears on a branch that falls through
  a_r5_flag_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cc |-> op_cbr && !redirect && (next_pc == pc_cur + XLEN'(ins_len)));

  // R10: stop suppresses every other effect
  a_r10_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    op_stop |-> halt && !link_we && !illegal_cc);

endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;

  localparam logic [63:0] RST_PC = 64'h0000_0000_0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [63:0] pc_cur;
  logic [3:0]  ins_len;
  logic        op_stop, op_ret, op_call, op_jmp, op_cbr;
  logic [3:0]  cond;
  logic [63:0] opnd_a, opnd_b;
  logic [31:0] br_target;
  logic [63:0] ret_addr;
  logic [63:0] next_pc;
  logic        halt, redirect, illegal_cc, link_we;
  logic [63:0] link_data;
  logic [63:0] pc_q;

  int tests = 0;
  int fails = 0;
  logic [63:0] exp_pcq;

  always #2.5 clk = ~clk;

  npc_unit #(.RESET_PC(RST_PC)) u_npc_unit (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .pc_cur(pc_cur),
    .ins_len(ins_len), .op_stop(op_stop), .op_ret(op_ret), .op_call(op_call),
    .op_jmp(op_jmp), .op_cbr(op_cbr), .cond(cond), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .br_target(br_target), .ret_addr(ret_addr),
    .next_pc(next_pc), .halt(halt), .redirect(redirect),
    .illegal_cc(illegal_cc), .link_we(link_we), .link_data(link_data),
    .pc_q(pc_q)
  );

  typedef struct packed {
    logic [63:0] nxt;
    logic        hlt;
    logic        red;
    logic        ill;
    logic        lwe;
    logic [63:0] ldat;
  } exp_t;

  function automatic logic s_less(input logic [63:0] x, input logic [63:0] y);
    logic [63:0] fx, fy;
    fx = x ^ 64'h8000_0000_0000_0000;
    fy = y ^ 64'h8000_0000_0000_0000;
    return fx < fy;
  endfunction

  function automatic logic [1:0] branch_model(input logic [3:0] c,
                                              input logic [63:0] x,
                                              input logic [63:0] y);
    // returns {reserved, taken}
    case (c)
      4'h0: return {1'b0, x == y};
      4'h1: return {1'b0, x != y};
      4'h4: return {1'b0, s_less(x, y)};
      4'h5: return {1'b0, !s_less(y, x)};
      4'h6: return {1'b0, s_less(y, x)};
      4'h7: return {1'b0, !s_less(x, y)};
      4'h8: return {1'b0, x > y};
      4'h9: return {1'b0, x >= y};
      4'hA: return {1'b0, x < y};
      4'hB: return {1'b0, x <= y};
      default: return 2'b10;
    endcase
  endfunction

  function automatic exp_t model();
    exp_t e;
    logic [63:0] seq;
    logic [1:0]  br;
    seq = pc_cur + {60'd0, ins_len};
    e.nxt = seq; e.hlt = 0; e.red = 0; e.ill = 0; e.lwe = 0; e.ldat = seq;
    if (op_stop) begin
      e.hlt = 1; e.nxt = pc_cur;
    end else if (op_ret) begin
      if (ret_addr == 64'd0 || ret_addr[63]) begin
        e.hlt = 1; e.nxt = pc_cur;
      end else begin
        e.red = 1; e.nxt = ret_addr;
      end
    end else if (op_call) begin
      e.lwe = 1; e.red = 1; e.nxt = {32'd0, br_target};
    end else if (op_jmp) begin
      e.red = 1; e.nxt = {32'd0, br_target};
    end else if (op_cbr) begin
      br = branch_model(cond, opnd_a, opnd_b);
      e.ill = br[1];
      if (br[0]) begin
        e.red = 1; e.nxt = {32'd0, br_target};
      end
    end
    return e;
  endfunction

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag,
                       input logic st, input logic rt, input logic cl,
                       input logic jp, input logic cb, input logic [3:0] c,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] pc, input logic [3:0] len,
                       input logic [31:0] tgt, input logic [63:0] ra,
                       input logic en);
    exp_t e;
    @(negedge clk);
    check64("R11", "pc_q", pc_q, exp_pcq);
    op_stop = st; op_ret = rt; op_call = cl; op_jmp = jp; op_cbr = cb;
    cond = c; opnd_a = a; opnd_b = b; pc_cur = pc; ins_len = len;
    br_target = tgt; ret_addr = ra; step_en = en;
    #1;
    e = model();
    check64(tag, "next_pc", next_pc, e.nxt);
    check64(tag, "halt", {63'd0, halt}, {63'd0, e.hlt});
    check64(tag, "redirect", {63'd0, redirect}, {63'd0, e.red});
    check64(tag, "illegal_cc", {63'd0, illegal_cc}, {63'd0, e.ill});
    check64(tag, "link_we", {63'd0, link_we}, {63'd0, e.lwe});
    if (e.lwe) check64(tag, "link_data", link_data, e.ldat);
    if (en) exp_pcq = e.nxt;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] edge_v [6];
    void'($urandom(32'd20211216));
    edge_v[0] = 64'd0; edge_v[1] = 64'd1; edge_v[2] = '1;
    edge_v[3] = 64'h8000_0000_0000_0000; edge_v[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    edge_v[5] = 64'h0000_0000_0000_002A;
    rst_n = 0; step_en = 0; pc_cur = 0; ins_len = 0;
    op_stop = 0; op_ret = 0; op_call = 0; op_jmp = 0; op_cbr = 0;
    cond = 0; opnd_a = 0; opnd_b = 0; br_target = 0; ret_addr = 0;
    exp_pcq = RST_PC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("R11", "reset pc_q", pc_q, RST_PC);
    check64("R1", "reset next_pc", next_pc, 64'd0);
    rst_n = 1;

    // R1 sequential flow and wrap
    apply("R1", 0,0,0,0,0, 4'h0, 1, 2, 64'h100, 4'd2, 32'h40, 0, 1);
    apply("R1", 0,0,0,0,0, 4'h0, 1, 2, 64'hFFFF_FFFF_FFFF_FFFE, 4'd6, 32'h40, 0, 1);
    // R2 equality
    apply("R2", 0,0,0,0,1, 4'h0, 64'd42, 64'd42, 64'h20, 4'd6, 32'h3D, 0, 1);
    apply("R2", 0,0,0,0,1, 4'h0, 64'd42, 64'd41, 64'h20, 4'd6, 32'h3D, 0, 1);
    apply("R2", 0,0,0,0,1, 4'h1, 64'd5, 64'd5, 64'h20, 4'd6, 32'h3D, 0, 1);
    apply("R2", 0,0,0,0,1, 4'h1, 64'd5, 64'd6, 64'h20, 4'd10, 32'h3D, 0, 1);
    // R3 signed, where signed and unsigned disagree
    apply("R3", 0,0,0,0,1, 4'h4, '1, 64'd1, 64'h30, 4'd6, 32'h11, 0, 0);
    apply("R3", 0,0,0,0,1, 4'h6, '1, 64'd1, 64'h30, 4'd6, 32'h11, 0, 0);
    apply("R3", 0,0,0,0,1, 4'h5, 64'd7, 64'd7, 64'h30, 4'd6, 32'h11, 0, 0);
    apply("R3", 0,0,0,0,1, 4'h7, 64'h8000_0000_0000_0000, 64'd0, 64'h30, 4'd6, 32'h11, 0, 1);
    apply("R3", 0,0,0,0,1, 4'h6, 64'd7, 64'd7, 64'h30, 4'd6, 32'h11, 0, 1);
    // R4 unsigned
    apply("R4", 0,0,0,0,1, 4'h8, '1, 64'd1, 64'h30, 4'd6, 32'h11, 0, 1);
    apply("R4", 0,0,0,0,1, 4'hA, '1, 64'd1, 64'h30, 4'd6, 32'h11, 0, 1);
    apply("R4", 0,0,0,0,1, 4'h9, 64'd9, 64'd9, 64'h30, 4'd6, 32'h11, 0, 1);
    apply("R4", 0,0,0,0,1, 4'hB, 64'd9, 64'd9, 64'h30, 4'd6, 32'h11, 0, 1);
    apply("R4", 0,0,0,0,1, 4'h8, 64'd9, 64'd9, 64'h30, 4'd6, 32'h11, 0, 1);
    // R5 reserved codes
    foreach (edge_v[i]) begin end
    apply("R5", 0,0,0,0,1, 4'h2, 64'd3, 64'd3, 64'h50, 4'd6, 32'h99, 0, 1);
    apply("R5", 0,0,0,0,1, 4'h3, 64'd3, 64'd4, 64'h50, 4'd6, 32'h99, 0, 1);
    apply("R5", 0,0,0,0,1, 4'hC, 64'd3, 64'd3, 64'h50, 4'd10, 32'h99, 0, 1);
    apply("R5", 0,0,0,0,1, 4'hF, 64'd3, 64'd3, 64'h50, 4'd10, 32'h99, 0, 1);
    apply("R5", 0,0,0,1,0, 4'hF, 64'd3, 64'd3, 64'h50, 4'd6, 32'h99, 0, 1);
    // R6 jump
    apply("R6", 0,0,0,1,0, 4'h1, 64'd3, 64'd3, 64'h0B, 4'd6, 32'hFFFF_FF25, 0, 1);
    // R7 call
    apply("R7", 0,0,1,0,0, 4'h0, 0, 0, 64'h200, 4'd6, 32'h800, 0, 1);
    // R8 return good, zero, negative
    apply("R8", 0,1,0,0,0, 4'h0, 0, 0, 64'h45, 4'd2, 32'h0, 64'h206, 1);
    apply("R8", 0,1,0,0,0, 4'h0, 0, 0, 64'h45, 4'd2, 32'h0, 64'h0, 1);
    apply("R8", 0,1,0,0,0, 4'h0, 0, 0, 64'h45, 4'd2, 32'h0, 64'h8000_0000_0000_0010, 1);
    // R9 stop
    apply("R9", 1,0,0,0,0, 4'h0, 0, 0, 64'h2C, 4'd2, 32'h0, 0, 1);
    // R10 priority
    apply("R10", 1,1,1,1,1, 4'h0, 0, 0, 64'h60, 4'd2, 32'h77, 64'h300, 1);
    apply("R10", 0,1,1,1,1, 4'h0, 0, 0, 64'h60, 4'd2, 32'h77, 64'h300, 1);
    apply("R10", 0,0,1,1,1, 4'h2, 0, 0, 64'h60, 4'd2, 32'h77, 64'h300, 1);
    apply("R10", 0,0,0,1,1, 4'hC, 0, 1, 64'h60, 4'd2, 32'h78, 64'h300, 1);
    // R11 hold with enable low
    apply("R11", 0,0,0,1,0, 4'h0, 0, 0, 64'h60, 4'd2, 32'h1234, 0, 0);
    apply("R11", 0,0,0,0,0, 4'h0, 0, 0, 64'h64, 4'd2, 32'h0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0]  cls;
      logic [63:0] a, b, ra;
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0: cls = 5'b10000;
        1: cls = 5'b01000;
        2: cls = 5'b00100;
        3: cls = 5'b00010;
        4: cls = 5'($urandom);
        5: cls = 5'b00000;
        default: cls = 5'b00001;
      endcase
      a = ($urandom_range(0, 2) == 0) ? edge_v[$urandom_range(0, 5)]
                                      : {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: b = a;
        1: b = edge_v[$urandom_range(0, 5)];
        default: b = {$urandom, $urandom};
      endcase
      case ($urandom_range(0, 3))
        0: ra = 64'd0;
        1: ra = {1'b1, 31'($urandom), 32'($urandom)};
        default: ra = {32'd0, $urandom};
      endcase
      apply("R1/R2/R3/R4/R5/R6/R7/R8/R9/R10 random",
            cls[4], cls[3], cls[2], cls[1], cls[0], 4'($urandom),
            a, b, {$urandom, $urandom}, 4'($urandom), $urandom, ra,
            1'($urandom));
    end

    @(negedge clk);
    check64("R11", "final pc_q", pc_q, exp_pcq);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule